// File: doc/BRIEF.md
# Skewed Systolic Ones Counter

This block reports how many bits are set in a W-bit input vector. It takes a new vector on every clock and returns one count per clock. The vector's bits do not meet in an adder tree. Bit k is held back k cycles in a triangular lattice of registers and then drops into row k of a column of carry-save accumulator rows. Each row is a single 3:2 compressor layer. It folds its bit into a redundant (sum, carry) pair and passes the pair down to the next row. Every wire therefore runs between neighbouring registers.

Under the last row sits a short settling pipeline of ceil(log2(W+1)) stages. Each stage is one half-adder layer. These stages turn the redundant pair into an ordinary binary count. A valid flag travels down the same path, so results come out in the order the vectors went in, with gaps where the input had gaps.

The reset input is active low. It is asserted asynchronously and released synchronously inside the block.

Top module: `popc_systolic`

## Requirements
- R1: While reset is asserted, and after release until a vector has passed the full pipeline, `out_valid` stays low.
- R2: For every vector accepted with `in_valid` high, the matching `out_count` equals the number of 1 bits in that vector, as an unsigned binary value of CW = ceil(log2(W+1)) bits.
- R3: The count for a vector appears with `out_valid` high right after rising edge number W+CW. The edge that samples the vector with `in_valid` high is counted as edge 1.
- R4: Vectors offered on consecutive cycles are all accepted, with no stall. Their counts leave on consecutive cycles in the same order.
- R5: An all-zero vector yields a count of 0. An all-ones vector yields a count of W, which for W=16 sets only bit 4 of `out_count`.
- R6: A cycle with `in_valid` low produces no result, whatever value `in_vec` holds. `out_valid` is high only for accepted vectors, once each.
- R7: Asserting reset discards every vector in flight. None of them produces `out_valid` after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| in_valid | input | 1 | Qualifies `in_vec` in this cycle |
| in_vec | input | W | Vector whose set bits are counted |
| out_valid | output | 1 | `out_count` holds a result this cycle |
| out_count | output | CW | Number of set bits, CW = ceil(log2(W+1)) |

## Verification
The bench builds the block with its default width, W=16. That gives CW=5, a latency of 21 edges and 16 accumulator rows. The all-ones vector then produces a count of 16, which is a power of two. Reaching that count forces a carry through every settling stage into the top output bit. The width also leaves sixteen distinct single-bit positions, each of which travels a different skew depth. A pipeline of 21 slots holds enough vectors to test back-to-back streams, streams with gaps and a reset that lands while many vectors are in flight.

// File: rtl/popc_pkg.sv
`timescale 1ns/1ps
package popc_pkg;

  // bits needed to hold a count from 0 to n inclusive
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // half-adder layers needed to flatten a redundant pair of that width
  function automatic int unsigned settle_depth(input int unsigned n);
    return count_width(n);
  endfunction

endpackage

// File: rtl/popc_skew.sv
`timescale 1ns/1ps
// Triangular delay lattice: lane k delays its bit by k cycles.
module popc_skew #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] in_vec,
  output logic [W-1:0] out_bits
);

  assign out_bits[0] = in_vec[0];

  for (genvar k = 1; k < W; k++) begin : g_lane
    logic [k-1:0] lane_q;
    if (k == 1) begin : g_one
      always_ff @(posedge clk) begin
        lane_q <= in_vec[k];
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        lane_q <= {lane_q[k-2:0], in_vec[k]};
      end
    end
    assign out_bits[k] = lane_q[k-1];
  end

endmodule

// File: rtl/popc_csa_row.sv
`timescale 1ns/1ps
// One accumulator row: folds a single bit into a redundant (sum, carry) pair.
module popc_csa_row #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [CW-1:0] up_sum,
  input  logic [CW-1:0] up_carry,
  input  logic          side_bit,
  output logic          dn_valid,
  output logic [CW-1:0] dn_sum,
  output logic [CW-1:0] dn_carry
);

  logic [CW-1:0] bit_vec;
  logic [CW-1:0] sum_d, carry_d;
  logic [CW-1:0] sum_q, carry_q;
  logic          valid_q;

  always_comb begin
    bit_vec = '0;
    bit_vec[0] = side_bit;
    sum_d   = up_sum ^ up_carry ^ bit_vec;
    carry_d = ((up_sum & up_carry) | (up_sum & bit_vec) | (up_carry & bit_vec)) << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  assign dn_valid = valid_q;
  assign dn_sum   = sum_q;
  assign dn_carry = carry_q;

endmodule

// File: rtl/popc_settle.sv
`timescale 1ns/1ps
// One half-adder layer: moves carries up by one place while keeping the pair's value.
module popc_settle #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  input  logic [CW-1:0] up_sum,
  input  logic [CW-1:0] up_carry,
  output logic          dn_valid,
  output logic [CW-1:0] dn_sum,
  output logic [CW-1:0] dn_carry
);

  logic [CW-1:0] sum_d, carry_d;
  logic [CW-1:0] sum_q, carry_q;
  logic          valid_q;

  always_comb begin
    sum_d   = up_sum ^ up_carry;
    carry_d = (up_sum & up_carry) << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  assign dn_valid = valid_q;
  assign dn_sum   = sum_q;
  assign dn_carry = carry_q;

endmodule

// File: rtl/popc_systolic.sv
`timescale 1ns/1ps
module popc_systolic #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = popc_pkg::count_width(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_vec,
  output logic          out_valid,
  output logic [CW-1:0] out_count
);

  localparam int unsigned RS = popc_pkg::settle_depth(W);

  // reset: asynchronous assert, two-flop synchronous release
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rsync_q[1];

  // skew lattice
  logic [W-1:0] lane_bits;

  popc_skew #(.W(W)) u_skew (
    .clk      (clk),
    .in_vec   (in_vec),
    .out_bits (lane_bits)
  );

  // accumulator column
  logic [W:0]         row_v;
  logic [W:0][CW-1:0] row_s;
  logic [W:0][CW-1:0] row_c;

  assign row_v[0] = in_valid;
  assign row_s[0] = '0;
  assign row_c[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_row
    popc_csa_row #(.CW(CW)) u_row (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .up_valid (row_v[k]),
      .up_sum   (row_s[k]),
      .up_carry (row_c[k]),
      .side_bit (lane_bits[k]),
      .dn_valid (row_v[k+1]),
      .dn_sum   (row_s[k+1]),
      .dn_carry (row_c[k+1])
    );
  end

  // settling pipeline
  logic [RS:0]         st_v;
  logic [RS:0][CW-1:0] st_s;
  logic [RS:0][CW-1:0] st_c;

  assign st_v[0] = row_v[W];
  assign st_s[0] = row_s[W];
  assign st_c[0] = row_c[W];

  for (genvar j = 0; j < RS; j++) begin : g_settle
    popc_settle #(.CW(CW)) u_settle (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .up_valid (st_v[j]),
      .up_sum   (st_s[j]),
      .up_carry (st_c[j]),
      .dn_valid (st_v[j+1]),
      .dn_sum   (st_s[j+1]),
      .dn_carry (st_c[j+1])
    );
  end

  logic [CW-1:0] fin_carry;
  assign fin_carry = st_c[RS];

  assign out_valid = st_v[RS];
  assign out_count = st_s[RS];

endmodule

// File: rtl/popc_systolic_chk.sv
`timescale 1ns/1ps
module popc_systolic_chk #(
  parameter int unsigned W   = 16,
  parameter int unsigned CW  = 5,
  parameter int unsigned LAT = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_vec,
  input logic          out_valid,
  input logic [CW-1:0] out_count,
  input logic          fin_v,
  input logic [CW-1:0] fin_carry
);

  localparam int unsigned TW = $clog2(LAT + 1);

  logic [LAT-1:0]         vq;
  logic [LAT-1:0][CW-1:0] cq;
  logic [TW-1:0]          since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq      <= '0;
      since_q <= '0;
    end else begin
      vq <= {vq[LAT-2:0], in_valid};
      if (int'(since_q) < LAT) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    cq <= {cq[LAT-2:0], CW'($countones(in_vec))};
  end

  // R1
  startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_q) < LAT) |-> !out_valid);

  // R3
  valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vq[LAT-1]);

  // R2
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count == cq[LAT-1]));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_count) <= W));

  // R2
  carry_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_v |-> (fin_carry == '0));

endmodule

bind popc_systolic popc_systolic_chk #(.W(W), .CW(CW), .LAT(W + CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_count (out_count),
  .fin_v     (out_valid),
  .fin_carry (fin_carry)
);

// File: tb/popc_systolic_bench.sv
`timescale 1ns/1ps
module popc_systolic_bench;

  localparam int W   = 16;
  localparam int CW  = $clog2(W + 1);
  localparam int LAT = W + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_vec = '0;
  logic          out_valid;
  logic [CW-1:0] out_count;

  always #5 clk = ~clk;

  popc_systolic #(.W(W)) u_popc_systolic (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_count (out_count)
  );

  typedef struct {
    int    exp;
    int    issue;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // result monitor: order, value and latency of each returned count
  always @(negedge clk) begin
    item_t it;
    if (out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R6 result with nothing pending", 1, 0);
      end else begin
        it = q.pop_front();
        check(int'(out_count) == it.exp, {it.tag, " count"}, int'(out_count), it.exp);
        check(cyc == it.issue + LAT - 1, "R3 latency in edges", cyc - it.issue + 1, LAT);
      end
    end
  end

  task automatic send(input bit v, input logic [W-1:0] vec, input string tag);
    @(negedge clk);
    in_valid = v;
    in_vec   = vec;
    if (v) q.push_back('{$countones(vec), cyc + 1, tag});
  endtask

  task automatic drain(input string tag);
    repeat (LAT + 4) send(1'b0, '0, "");
    check(q.size() == 0, tag, q.size(), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!out_valid, "R1 low during reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    repeat (LAT + 5) begin
      @(negedge clk);
      check(!out_valid, "R1 low after release", int'(out_valid), 0);
    end
  endtask

  task automatic t_extremes();
    send(1'b1, '0, "R5 all zero");
    send(1'b1, '1, "R5 all ones");
    send(1'b1, '0, "R5 zero after ones");
    drain("R5 all returned");
  endtask

  task automatic t_patterns();
    for (int i = 0; i < W; i++) send(1'b1, W'(1) << i, "R2 single bit");
    send(1'b1, 16'hAAAA, "R2 alternating");
    send(1'b1, 16'h00FF, "R2 low half");
    send(1'b1, 16'hFF00, "R2 high half");
    send(1'b1, 16'h7FFF, "R2 all but top");
    drain("R2 all returned");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 300; i++) send(1'b1, W'($urandom), "R4 back-to-back");
    drain("R4 all returned in order");
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 200; i++) send(($urandom % 3) != 0, W'($urandom), "R6 gapped stream");
    drain("R6 no extra or missing results");
  endtask

  task automatic t_midreset();
    for (int i = 0; i < 6; i++) send(1'b1, W'($urandom) | 1, "R7 in flight");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q.delete();
    repeat (3) begin
      @(negedge clk);
      check(!out_valid, "R7 low while reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    repeat (LAT + 5) begin
      @(negedge clk);
      check(!out_valid, "R7 flushed vectors stay gone", int'(out_valid), 0);
    end
    send(1'b1, 16'h0F0F, "R7 resumed");
    send(1'b1, 16'hFFFF, "R7 resumed");
    drain("R7 resumed results");
  endtask

  initial begin
    t_reset();
    t_extremes();
    t_patterns();
    t_stream();
    t_gaps();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule